// File: doc/BRIEF.md
# Event-Matched Programmable Trigger Unit

This block sits behind a link receiver that delivers one decoded word per clock: an 8-bit event code and an 8-bit data byte, qualified by a valid strobe. Every event code is looked up in a host-written mapping memory with one entry per code value. Each entry is a mask that names the trigger outputs the code should fire. A hit starts a cycle-counted delay on each selected output. When the delay has run out, that output holds its active level for a programmed number of cycles. Delay, width, enable and polarity are held separately for every output, so one broadcast event can place many edges at different times across a machine cycle.

The same word stream fills a 256-byte receive buffer. This lets frame payloads such as beam pattern or timestamp bytes reach the host. A programmable frame-open code rewinds the write address and a programmable frame-close code flags the buffer as complete. The host programs the unit through a single write port: the top four address bits select a register group and the low eight bits give an index. The host reads the buffer through a separate registered read port.

Top module: `evtrig_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `trig_out` is all zero, `retrig_flag` is all zero and `buf_ready` is 0. At reset, polarity is active-high and every output is disabled.
- R2: Host writes with address group 0x0 store the low `NUM_OUT` data bits as the output mask for event code `host_addr[7:0]`. A valid word whose code has mask bit i set fires output i if that output is enabled. All outputs named by one code fire on the same cycle, and outputs not in the mask keep their inactive level.
- R3: Event code 0x00 never fires any output, whatever its mapping entry holds.
- R4: Group 0x1 sets output `host_addr[3:0]`'s delay D and group 0x2 sets its width W. If a code is sampled on clock edge k, the output is at its active level from edge k+1+D through edge k+D+W, and inactive from edge k+1+D+W. A width of 0 acts as 1.
- R5: Delay and width hold `DLY_W`/`WID_W` bits (28 by default, above the 27 needed for a one-second range at 119 MHz). A delay above 65535 cycles is honoured exactly.
- R6: If an output fires while it is still delaying or pulsing, its timing restarts from the new code and its sticky `retrig_flag` bit is set. A single trigger on an idle output leaves the flag clear. A group 0x5 write clears the flags whose data bits are 1.
- R7: Group 0x3 data bit 0 enables output `host_addr[3:0]` and bit 1 selects polarity (1 = active low). The inactive level equals the polarity bit, and it applies also while the output is disabled. A disabled output never fires.
- R8: Each valid word writes its data byte into the buffer. A word whose code equals the frame-open code (group 0x4, data bits 7:0) writes to address 0, and the words after it go to incrementing addresses. `buf_rdata` returns the byte at `buf_raddr` one cycle later.
- R9: A word whose code equals the frame-close code (group 0x4, data bits 15:8) sets `buf_ready` on the edge that samples it. A frame-open word clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Decoded word qualifier |
| rx_code | input | 8 | Event code of the word |
| rx_data | input | 8 | Data byte of the word |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Group in bits 11:8, index in bits 7:0 |
| host_wdata | input | 32 | Host write data |
| buf_raddr | input | 8 | Receive buffer read address |
| buf_rdata | output | 8 | Receive buffer read data, one cycle latency |
| buf_ready | output | 1 | Frame-close code seen since last frame-open |
| trig_out | output | 14 | Registered trigger outputs |
| retrig_flag | output | 14 | Sticky per-output retrigger indication |

## Verification
The bench builds the unit with its default parameters: 14 outputs, 8-bit codes, 28-bit delay and width counters and a 256-byte buffer. It can therefore check that one code fans out to several outputs while the unmapped ones and a disabled active-low output hold still. A 70000-cycle delay drives the counter past bit 16, which brings the long-range requirement within reach inside the run. Short delays of 0, 1 and 2 cycles and a zero width pin the edge-exact timing, and a retrigger during a 10-cycle delay shows the restart.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_DELAY = 2'd1,
    CH_PULSE = 2'd2
  } ch_state_e;

  typedef enum logic [3:0] {
    SEL_MAP   = 4'h0,
    SEL_DELAY = 4'h1,
    SEL_WIDTH = 4'h2,
    SEL_CTRL  = 4'h3,
    SEL_CODES = 4'h4,
    SEL_RTCLR = 4'h5
  } host_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_POL_BIT = 1;

endpackage

// File: rtl/evtrig_cfg.sv
module evtrig_cfg
  import evtrig_pkg::*;
#(
  parameter int NUM_OUT = 14,
  parameter int CODE_W  = 8,
  parameter int DLY_W   = 28,
  parameter int WID_W   = 28,
  parameter int HOST_AW = 12,
  parameter int HOST_DW = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            host_we,
  input  logic [HOST_AW-1:0]              host_addr,
  input  logic [HOST_DW-1:0]              host_wdata,
  output logic [NUM_OUT-1:0][DLY_W-1:0]   dly_cfg,
  output logic [NUM_OUT-1:0][WID_W-1:0]   wid_cfg,
  output logic [NUM_OUT-1:0]              en_cfg,
  output logic [NUM_OUT-1:0]              pol_cfg,
  output logic [CODE_W-1:0]               start_code,
  output logic [CODE_W-1:0]               end_code,
  output logic [NUM_OUT-1:0]              rt_clr,
  output logic                            map_we,
  output logic [CODE_W-1:0]               map_waddr,
  output logic [NUM_OUT-1:0]              map_wdata
);

  localparam int IDX_W = 8;

  logic [3:0]       sel;
  logic [IDX_W-1:0] idx;

  assign sel = host_addr[HOST_AW-1 -: 4];
  assign idx = host_addr[IDX_W-1:0];

  assign map_we    = host_we && (sel == SEL_MAP);
  assign map_waddr = host_addr[CODE_W-1:0];
  assign map_wdata = host_wdata[NUM_OUT-1:0];
  assign rt_clr    = (host_we && (sel == SEL_RTCLR)) ? host_wdata[NUM_OUT-1:0] : '0;

  logic unused_host_bits;
  assign unused_host_bits = ^{host_addr, host_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_cfg    <= '0;
      for (int i = 0; i < NUM_OUT; i++) wid_cfg[i] <= WID_W'(1);
      en_cfg     <= '0;
      pol_cfg    <= '0;
      start_code <= '0;
      end_code   <= '0;
    end else if (host_we) begin
      case (sel)
        SEL_DELAY: begin
          for (int i = 0; i < NUM_OUT; i++)
            if (idx == IDX_W'(i)) dly_cfg[i] <= host_wdata[DLY_W-1:0];
        end
        SEL_WIDTH: begin
          for (int i = 0; i < NUM_OUT; i++)
            if (idx == IDX_W'(i)) wid_cfg[i] <= host_wdata[WID_W-1:0];
        end
        SEL_CTRL: begin
          for (int i = 0; i < NUM_OUT; i++)
            if (idx == IDX_W'(i)) begin
              en_cfg[i]  <= host_wdata[CTRL_EN_BIT];
              pol_cfg[i] <= host_wdata[CTRL_POL_BIT];
            end
        end
        SEL_CODES: begin
          start_code <= host_wdata[CODE_W-1:0];
          end_code   <= host_wdata[2*CODE_W-1:CODE_W];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/evtrig_map.sv
module evtrig_map #(
  parameter int NUM_OUT = 14,
  parameter int CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               map_we,
  input  logic [CODE_W-1:0]  map_waddr,
  input  logic [NUM_OUT-1:0] map_wdata,
  input  logic               rx_valid,
  input  logic [CODE_W-1:0]  rx_code,
  input  logic [NUM_OUT-1:0] en,
  output logic [NUM_OUT-1:0] fire
);

  localparam int DEPTH = 1 << CODE_W;

  logic [NUM_OUT-1:0] mem [DEPTH];
  logic [NUM_OUT-1:0] mask_q;
  logic               hit_q;

  always_ff @(posedge clk) begin
    if (map_we) mem[map_waddr] <= map_wdata;
  end

  always_ff @(posedge clk) begin
    mask_q <= mem[rx_code];
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= rx_valid && (rx_code != '0);
  end

  assign fire = hit_q ? (mask_q & en) : '0;

endmodule

// File: rtl/evtrig_chan.sv
module evtrig_chan
  import evtrig_pkg::*;
#(
  parameter int DLY_W = 28,
  parameter int WID_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             en,
  input  logic             pol,
  input  logic [DLY_W-1:0] dly,
  input  logic [WID_W-1:0] wid,
  input  logic             rt_clr,
  output logic             out_q,
  output logic             retrig_q
);

  localparam int CNT_W = (DLY_W > WID_W) ? DLY_W : WID_W;

  ch_state_e  state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             act_n;
  logic [CNT_W-1:0] wid_m1;
  logic [CNT_W-1:0] dly_m1;

  assign wid_m1 = (wid == '0) ? '0 : CNT_W'(wid) - CNT_W'(1);
  assign dly_m1 = CNT_W'(dly) - CNT_W'(1);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    act_n   = 1'b0;
    if (!en) begin
      state_n = CH_IDLE;
      cnt_n   = '0;
    end else if (fire) begin
      if (dly == '0) begin
        state_n = CH_PULSE;
        cnt_n   = wid_m1;
        act_n   = 1'b1;
      end else begin
        state_n = CH_DELAY;
        cnt_n   = dly_m1;
      end
    end else begin
      case (state)
        CH_DELAY: begin
          if (cnt == '0) begin
            state_n = CH_PULSE;
            cnt_n   = wid_m1;
            act_n   = 1'b1;
          end else begin
            cnt_n = cnt - CNT_W'(1);
          end
        end
        CH_PULSE: begin
          if (cnt == '0) begin
            state_n = CH_IDLE;
          end else begin
            cnt_n = cnt - CNT_W'(1);
            act_n = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CH_IDLE;
      cnt      <= '0;
      out_q    <= 1'b0;
      retrig_q <= 1'b0;
    end else begin
      state    <= state_n;
      cnt      <= cnt_n;
      out_q    <= act_n ^ pol;
      retrig_q <= (retrig_q & ~rt_clr) | (fire & (state != CH_IDLE));
    end
  end

endmodule

// File: rtl/evtrig_dbuf.sv
module evtrig_dbuf #(
  parameter int BUF_AW = 8,
  parameter int CODE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CODE_W-1:0] rx_code,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [CODE_W-1:0] start_code,
  input  logic [CODE_W-1:0] end_code,
  input  logic [BUF_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready,
  output logic [BUF_AW-1:0] wptr
);

  localparam int DEPTH = 1 << BUF_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              is_start;
  logic              is_end;
  logic [BUF_AW-1:0] waddr;

  assign is_start = rx_valid && (rx_code == start_code);
  assign is_end   = rx_valid && (rx_code == end_code);
  assign waddr    = is_start ? '0 : wptr;

  always_ff @(posedge clk) begin
    if (rx_valid) mem[waddr] <= rx_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      ready <= 1'b0;
    end else begin
      if (rx_valid) wptr <= waddr + BUF_AW'(1);
      if (is_start)    ready <= 1'b0;
      else if (is_end) ready <= 1'b1;
    end
  end

endmodule

// File: rtl/evtrig_unit.sv
module evtrig_unit #(
  parameter int NUM_OUT = 14,
  parameter int CODE_W  = 8,
  parameter int DATA_W  = 8,
  parameter int DLY_W   = 28,
  parameter int WID_W   = 28,
  parameter int BUF_AW  = 8,
  parameter int HOST_AW = 12,
  parameter int HOST_DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_valid,
  input  logic [CODE_W-1:0]  rx_code,
  input  logic [DATA_W-1:0]  rx_data,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  input  logic [BUF_AW-1:0]  buf_raddr,
  output logic [DATA_W-1:0]  buf_rdata,
  output logic               buf_ready,
  output logic [NUM_OUT-1:0] trig_out,
  output logic [NUM_OUT-1:0] retrig_flag
);

  logic [NUM_OUT-1:0][DLY_W-1:0] dly_cfg;
  logic [NUM_OUT-1:0][WID_W-1:0] wid_cfg;
  logic [NUM_OUT-1:0]            en_vec;
  logic [NUM_OUT-1:0]            pol_vec;
  logic [NUM_OUT-1:0]            rt_clr;
  logic [NUM_OUT-1:0]            fire_vec;
  logic [CODE_W-1:0]             start_code;
  logic [CODE_W-1:0]             end_code;
  logic                          map_we;
  logic [CODE_W-1:0]             map_waddr;
  logic [NUM_OUT-1:0]            map_wdata;
  logic [BUF_AW-1:0]             buf_wptr;

  evtrig_cfg #(
    .NUM_OUT(NUM_OUT), .CODE_W(CODE_W), .DLY_W(DLY_W), .WID_W(WID_W),
    .HOST_AW(HOST_AW), .HOST_DW(HOST_DW)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .dly_cfg(dly_cfg), .wid_cfg(wid_cfg), .en_cfg(en_vec), .pol_cfg(pol_vec),
    .start_code(start_code), .end_code(end_code), .rt_clr(rt_clr),
    .map_we(map_we), .map_waddr(map_waddr), .map_wdata(map_wdata)
  );

  evtrig_map #(.NUM_OUT(NUM_OUT), .CODE_W(CODE_W)) u_map (
    .clk(clk), .rst(rst),
    .map_we(map_we), .map_waddr(map_waddr), .map_wdata(map_wdata),
    .rx_valid(rx_valid), .rx_code(rx_code), .en(en_vec),
    .fire(fire_vec)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
    evtrig_chan #(.DLY_W(DLY_W), .WID_W(WID_W)) u_chan (
      .clk(clk), .rst(rst),
      .fire(fire_vec[g]), .en(en_vec[g]), .pol(pol_vec[g]),
      .dly(dly_cfg[g]), .wid(wid_cfg[g]), .rt_clr(rt_clr[g]),
      .out_q(trig_out[g]), .retrig_q(retrig_flag[g])
    );
  end

  evtrig_dbuf #(.BUF_AW(BUF_AW), .CODE_W(CODE_W), .DATA_W(DATA_W)) u_dbuf (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_code(rx_code), .rx_data(rx_data),
    .start_code(start_code), .end_code(end_code),
    .rd_addr(buf_raddr), .rd_data(buf_rdata),
    .ready(buf_ready), .wptr(buf_wptr)
  );

endmodule

// File: rtl/evtrig_unit_chk.sv
module evtrig_unit_chk #(
  parameter int NUM_OUT = 14,
  parameter int CODE_W  = 8,
  parameter int BUF_AW  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               rx_valid,
  input logic [CODE_W-1:0]  rx_code,
  input logic [NUM_OUT-1:0] trig_out,
  input logic [NUM_OUT-1:0] retrig_flag,
  input logic               buf_ready,
  input logic [NUM_OUT-1:0] fire_vec,
  input logic [NUM_OUT-1:0] en_vec,
  input logic [NUM_OUT-1:0] pol_vec,
  input logic [CODE_W-1:0]  start_code,
  input logic [CODE_W-1:0]  end_code,
  input logic [BUF_AW-1:0]  buf_wptr
);

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (trig_out == '0 && retrig_flag == '0 && !buf_ready));

  // R3
  a_r3_code_zero_silent: assert property (@(posedge clk) disable iff (rst)
    $past(rx_valid && rx_code == '0) |-> (fire_vec == '0));

  // R6
  a_r6_flag_needs_fire: assert property (@(posedge clk) disable iff (rst)
    ((retrig_flag & ~$past(retrig_flag) & ~$past(fire_vec)) == '0));

  // R7
  a_r7_disabled_inactive: assert property (@(posedge clk) disable iff (rst)
    ((~$past(en_vec) & (trig_out ^ $past(pol_vec))) == '0));

  // R8
  a_r8_open_rewinds: assert property (@(posedge clk) disable iff (rst)
    $past(rx_valid && rx_code == start_code) |-> (buf_wptr == BUF_AW'(1)));

  // R9
  a_r9_ready_on_close: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_ready) |-> $past(rx_valid && rx_code == end_code));

endmodule

bind evtrig_unit evtrig_unit_chk #(
  .NUM_OUT(NUM_OUT), .CODE_W(CODE_W), .BUF_AW(BUF_AW)
) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_code(rx_code),
  .trig_out(trig_out), .retrig_flag(retrig_flag), .buf_ready(buf_ready),
  .fire_vec(fire_vec), .en_vec(en_vec), .pol_vec(pol_vec),
  .start_code(start_code), .end_code(end_code), .buf_wptr(buf_wptr)
);

// File: tb/sim_evtrig_unit.sv
`timescale 1ns/1ps
module sim_evtrig_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_code = '0;
  logic [7:0]  rx_data = '0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [7:0]  buf_raddr = '0;
  logic [7:0]  buf_rdata;
  logic        buf_ready;
  logic [13:0] trig_out;
  logic [13:0] retrig_flag;

  int checks = 0;
  int fails  = 0;
  logic [13:0] idle_lvl = '0;

  always #4 clk = ~clk;

  evtrig_unit u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_code(rx_code), .rx_data(rx_data),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .buf_ready(buf_ready),
    .trig_out(trig_out), .retrig_flag(retrig_flag)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] grp, input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = {grp, idx}; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_code = c; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // call right after send(): compares the whole output vector each cycle
  task automatic watch_pulse(input string tag, input logic [13:0] mask, input int d, input int w);
    logic [13:0] exp_v;
    logic [13:0] bad_a = '0, bad_e = '0;
    bit ok = 1'b1;
    for (int j = 1; j <= d + w + 2; j++) begin
      @(negedge clk);
      exp_v = idle_lvl ^ (((j >= d + 1) && (j <= d + w)) ? mask : 14'h0);
      if (trig_out !== exp_v && ok) begin
        ok = 1'b0; bad_a = trig_out; bad_e = exp_v;
      end
    end
    check(ok, tag, {18'h0, bad_a}, {18'h0, bad_e});
  endtask

  task automatic watch_quiet(input string tag, input int n);
    logic [13:0] bad_a = '0;
    bit ok = 1'b1;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (trig_out !== idle_lvl && ok) begin ok = 1'b0; bad_a = trig_out; end
    end
    check(ok, tag, {18'h0, bad_a}, {18'h0, idle_lvl});
  endtask

  task automatic read_buf(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    buf_raddr = a;
    @(negedge clk);
    check(buf_rdata === exp, tag, {24'h0, buf_rdata}, {24'h0, exp});
  endtask

  task automatic t_reset;
    check(trig_out === 14'h0, "R1 trig_out after reset", {18'h0, trig_out}, 0);
    check(retrig_flag === 14'h0, "R1 retrig_flag after reset", {18'h0, retrig_flag}, 0);
    check(buf_ready === 1'b0, "R1 buf_ready after reset", {31'h0, buf_ready}, 0);
  endtask

  task automatic t_setup;
    host_wr(4'h4, 8'h00, 32'h0000_F1F0);
    host_wr(4'h0, 8'h10, 32'h0001);
    host_wr(4'h0, 8'h20, 32'h0006);
    host_wr(4'h0, 8'h00, 32'h3FFF);
    host_wr(4'h0, 8'h30, 32'h0008);
    host_wr(4'h0, 8'h40, 32'h0010);
    host_wr(4'h0, 8'h50, 32'h0020);
    host_wr(4'h0, 8'h60, 32'h0040);
    host_wr(4'h0, 8'h33, 32'h0000);
    host_wr(4'h0, 8'hF0, 32'h0000);
    host_wr(4'h0, 8'hF1, 32'h0000);
    for (int i = 0; i < 7; i++) host_wr(4'h3, 8'(i), (i == 4) ? 32'h2 : (i == 5) ? 32'h3 : 32'h1);
    idle_lvl = 14'h0030;
    idle(2);
    check(trig_out === idle_lvl, "R7 inactive level follows polarity incl disabled",
          {18'h0, trig_out}, {18'h0, idle_lvl});
  endtask

  task automatic t_timing;
    host_wr(4'h1, 8'h00, 0); host_wr(4'h2, 8'h00, 1);
    send(8'h10, 8'h00); watch_pulse("R4 delay0 width1", 14'h0001, 0, 1);
    host_wr(4'h1, 8'h00, 5); host_wr(4'h2, 8'h00, 3);
    send(8'h10, 8'h00); watch_pulse("R4 delay5 width3", 14'h0001, 5, 3);
    host_wr(4'h1, 8'h03, 1); host_wr(4'h2, 8'h03, 0);
    send(8'h30, 8'h00); watch_pulse("R4 width0 acts as 1", 14'h0008, 1, 1);
    check(retrig_flag === 14'h0, "R6 single trigger leaves flag clear", {18'h0, retrig_flag}, 0);
  endtask

  task automatic t_fanout;
    host_wr(4'h1, 8'h01, 2); host_wr(4'h2, 8'h01, 4);
    host_wr(4'h1, 8'h02, 2); host_wr(4'h2, 8'h02, 4);
    send(8'h20, 8'h00); watch_pulse("R2 one code fires two outputs", 14'h0006, 2, 4);
  endtask

  task automatic t_code_zero;
    send(8'h00, 8'h00); watch_quiet("R3 code 0x00 fires nothing", 20);
  endtask

  task automatic t_polarity;
    host_wr(4'h1, 8'h05, 3); host_wr(4'h2, 8'h05, 2);
    send(8'h50, 8'h00); watch_pulse("R7 active-low pulse", 14'h0020, 3, 2);
    send(8'h40, 8'h00); watch_quiet("R7 disabled output never fires", 15);
  endtask

  task automatic t_retrig;
    host_wr(4'h1, 8'h00, 10); host_wr(4'h2, 8'h00, 4);
    send(8'h10, 8'h00);
    idle(3);
    send(8'h10, 8'h00); watch_pulse("R6 retrigger restarts timing", 14'h0001, 10, 4);
    check(retrig_flag === 14'h0001, "R6 retrigger flag set", {18'h0, retrig_flag}, 32'h1);
    host_wr(4'h5, 8'h00, 32'h1);
    check(retrig_flag === 14'h0, "R6 flag cleared by host", {18'h0, retrig_flag}, 0);
  endtask

  task automatic t_long;
    host_wr(4'h1, 8'h06, 70000); host_wr(4'h2, 8'h06, 2);
    send(8'h60, 8'h00); watch_pulse("R5 delay 70000 exact", 14'h0040, 70000, 2);
  endtask

  task automatic t_buffer;
    send(8'hF0, 8'hA0);
    check(buf_ready === 1'b0, "R9 not ready after open", {31'h0, buf_ready}, 0);
    send(8'h33, 8'hA1);
    send(8'h33, 8'hA2);
    check(buf_ready === 1'b0, "R9 not ready before close", {31'h0, buf_ready}, 0);
    send(8'hF1, 8'hA3);
    check(buf_ready === 1'b1, "R9 ready after close", {31'h0, buf_ready}, 1);
    read_buf(8'd0, 8'hA0, "R8 byte at 0");
    read_buf(8'd1, 8'hA1, "R8 byte at 1");
    read_buf(8'd2, 8'hA2, "R8 byte at 2");
    read_buf(8'd3, 8'hA3, "R8 byte at 3");
    send(8'hF0, 8'hB0);
    check(buf_ready === 1'b0, "R9 open clears ready", {31'h0, buf_ready}, 0);
    send(8'h33, 8'hB1);
    read_buf(8'd0, 8'hB0, "R8 open rewinds to 0");
    read_buf(8'd1, 8'hB1, "R8 next byte at 1");
    read_buf(8'd2, 8'hA2, "R8 later bytes untouched");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_setup;
    t_timing;
    t_fanout;
    t_code_zero;
    t_polarity;
    t_retrig;
    t_buffer;
    t_long;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule